// File: doc/BRIEF.md
# Fixed-Point PID Controller with Anti-Windup

This block is a sampled proportional-integral-derivative controller working in fixed point. Each accepted sample strobe takes a setpoint and a measurement, both signed Q1.14, and produces one saturated actuator command with a flag that reports clipping. The three gains are signed Q4.11 registers: a proportional gain, an integral gain already scaled by the sample period, and a derivative gain already divided by it. A fourth Q4.11 gain sets the anti-windup return rate. A Q1.14 coefficient sets how hard a first-order low-pass smooths the measurement before it is differenced.

The derivative acts on the filtered measurement, so a setpoint step adds no derivative kick. When the command clips, the integrator is pulled back by back-calculation. A mode input can select conditional integration instead, which freezes the integrator on clipped samples. Manual mode, disable and fault pass a tracked actuator value straight to the output. On every return to automatic control the integrator is preloaded so that the first automatic command equals that tracked value.

Top module: `pid_fixq`

## Requirements
- R1: A strobe accepted by an idle block raises `cmd_vld` for exactly one cycle, three clock cycles after the strobe cycle, and `cmd` and `cmd_sat` take the new result in that same cycle.
- R2: After a strobe is accepted, strobes in the next two cycles are ignored. A strobe in the cycle where `cmd_vld` is high is accepted.
- R3: The error is e = sat16(setpoint − meas). The proportional term is P = sat16(rnd(kp·e, 11)), where rnd(x, s) = floor((x + 2^(s−1)) / 2^s), which rounds to nearest with ties going upward.
- R4: Each sample the filtered measurement becomes yf ← sat16(yf + rnd((meas − yf)·lpf_beta, 14)). On the first sample after reset, yf is loaded with meas.
- R5: The derivative term is D = sat16(−rnd(kd·(yf_new − yf_old), 11)). It is zero on the first sample after reset, and a change in setpoint alone leaves it unchanged.
- R6: In automatic operation, I_pre = sat32(I + rnd(ki·e, 11)). The unclipped command P + I_pre + D is formed exactly, with no wrap.
- R7: The output is the unclipped command clamped to [cmd_lo, cmd_hi]. `cmd_sat` is 1 exactly when clamping changed the value.
- R8: With `aw_cond` = 0, a clipped automatic sample sets I ← sat32(I_pre + rnd(kt·(clipped − unclipped), 11)). An unclipped sample sets I ← I_pre.
- R9: With `aw_cond` = 1, a clipped automatic sample leaves the integrator at its previous value.
- R10: The first automatic sample after reset, or after any sample in manual, disabled or fault state, sets I ← sat32(trk_val − P − D) and outputs clamp(trk_val).
- R11: While not automatic (auto_sel = 0, run_en = 0 or fault = 1), the output is clamp(trk_val) and the flag reports clipping. The integrator is cleared when run_en = 0 or fault = 1.
- R12: The integrator saturates at the 32-bit signed limits and never wraps, so a long clipped run keeps the output at the same limit.
- R13: After reset `cmd` = 0, `cmd_sat` = 0 and `cmd_vld` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe |
| setpoint | input | 16 | Setpoint, signed Q1.14 |
| meas | input | 16 | Measurement, signed Q1.14 |
| kp | input | 16 | Proportional gain, signed Q4.11 |
| ki | input | 16 | Integral gain times sample period, signed Q4.11 |
| kd | input | 16 | Derivative gain over sample period, signed Q4.11 |
| kt | input | 16 | Back-calculation gain, signed Q4.11 |
| lpf_beta | input | 16 | Filter weight of the new measurement, Q1.14, 0 to 16384 |
| cmd_lo | input | 16 | Lower command limit, signed Q1.14 |
| cmd_hi | input | 16 | Upper command limit, signed Q1.14 |
| run_en | input | 1 | Controller enable |
| auto_sel | input | 1 | 1 selects automatic, 0 selects manual |
| fault | input | 1 | Fault, forces tracking and clears the integrator |
| aw_cond | input | 1 | 1 selects conditional integration, 0 selects back-calculation |
| trk_val | input | 16 | Tracked actuator value, signed Q1.14 |
| cmd | output | 16 | Clipped command, signed Q1.14 |
| cmd_sat | output | 1 | Command was clipped |
| cmd_vld | output | 1 | One-cycle result strobe |

## Verification
The hardest state to reach from the ports is a 32-bit integrator pinned at its limit. With the back-calculation gain at zero and the largest error and integral gain, the integrator needs about four thousand clipped samples to get there, and the bench runs that many. The bench then reverses the error and checks that the output stays at the same limit, which a wrapping integrator would not do. Back-to-back strobes held high across busy cycles exercise the acceptance window. Preload is brought about by mode transitions through manual, fault and disable.

// File: rtl/pidq_pkg.sv
package pidq_pkg;
    localparam int SIG_W     = 16;
    localparam int SIG_FRAC  = 14;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 11;
    localparam int ACC_W     = 32;
    localparam int WIDE_W    = 64;

    typedef struct packed {
        logic signed [SIG_W-1:0] err;
        logic signed [SIG_W:0]   dyf;
        logic signed [SIG_W-1:0] trk;
        logic                    act;
        logic                    clr;
    } fe_t;

    typedef struct packed {
        logic signed [SIG_W-1:0] p;
        logic signed [SIG_W-1:0] d;
        logic signed [ACC_W-1:0] kinc;
        logic signed [SIG_W-1:0] trk;
        logic                    act;
        logic                    clr;
    } te_t;

    // clamp a wide value to the range of a w-bit signed word
    function automatic logic signed [WIDE_W-1:0] sat_w(input logic signed [WIDE_W-1:0] x,
                                                      input int w);
        logic signed [WIDE_W-1:0] top;
        logic signed [WIDE_W-1:0] bot;
        top = (64'sd1 <<< (w - 1)) - 64'sd1;
        bot = -top - 64'sd1;
        if (x > top) return top;
        if (x < bot) return bot;
        return x;
    endfunction

    // drop s fraction bits, rounding to nearest with ties upward
    function automatic logic signed [WIDE_W-1:0] rnd_sh(input logic signed [WIDE_W-1:0] x,
                                                       input int s);
        return (x + (64'sd1 <<< (s - 1))) >>> s;
    endfunction

    function automatic logic signed [WIDE_W-1:0] clamp_w(input logic signed [WIDE_W-1:0] x,
                                                        input logic signed [WIDE_W-1:0] lo,
                                                        input logic signed [WIDE_W-1:0] hi);
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction
endpackage

// File: rtl/pidq_front.sv
module pidq_front
    import pidq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic signed [SIG_W-1:0] sp,
    input  logic signed [SIG_W-1:0] y,
    input  logic signed [SIG_W-1:0] beta,
    input  logic signed [SIG_W-1:0] trk,
    input  logic                    run_en,
    input  logic                    auto_sel,
    input  logic                    fault,
    output fe_t                     fe
);
    typedef struct packed {
        logic signed [SIG_W-1:0] yf;
        logic                    first;
        fe_t                     fe;
    } st_t;

    st_t st_d, st_q;

    logic signed [WIDE_W-1:0] yf_old_w;
    logic signed [WIDE_W-1:0] yf_new_w;
    logic signed [WIDE_W-1:0] step_w;

    always_comb begin
        st_d     = st_q;
        yf_old_w = st_q.first ? WIDE_W'(y) : WIDE_W'(st_q.yf);
        step_w   = rnd_sh((WIDE_W'(y) - yf_old_w) * WIDE_W'(beta), SIG_FRAC);
        yf_new_w = st_q.first ? WIDE_W'(y) : sat_w(yf_old_w + step_w, SIG_W);
        if (adv) begin
            st_d.yf     = SIG_W'(yf_new_w);
            st_d.first  = 1'b0;
            st_d.fe.err = SIG_W'(sat_w(WIDE_W'(sp) - WIDE_W'(y), SIG_W));
            st_d.fe.dyf = (SIG_W + 1)'(yf_new_w - yf_old_w);
            st_d.fe.trk = trk;
            st_d.fe.act = run_en & auto_sel & ~fault;
            st_d.fe.clr = ~run_en | fault;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{yf: '0, first: 1'b1, fe: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fe = st_q.fe;
endmodule

// File: rtl/pidq_terms.sv
module pidq_terms
    import pidq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  fe_t                      fe_i,
    input  logic signed [GAIN_W-1:0] kp,
    input  logic signed [GAIN_W-1:0] ki,
    input  logic signed [GAIN_W-1:0] kd,
    output te_t                      te
);
    te_t te_d, te_q;

    always_comb begin
        te_d = te_q;
        if (adv) begin
            te_d.p    = SIG_W'(sat_w(rnd_sh(WIDE_W'(kp) * WIDE_W'(fe_i.err), GAIN_FRAC), SIG_W));
            te_d.d    = SIG_W'(sat_w(-rnd_sh(WIDE_W'(kd) * WIDE_W'(fe_i.dyf), GAIN_FRAC), SIG_W));
            te_d.kinc = ACC_W'(sat_w(rnd_sh(WIDE_W'(ki) * WIDE_W'(fe_i.err), GAIN_FRAC), ACC_W));
            te_d.trk  = fe_i.trk;
            te_d.act  = fe_i.act;
            te_d.clr  = fe_i.clr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_q <= '0;
        end else begin
            te_q <= te_d;
        end
    end

    assign te = te_q;
endmodule

// File: rtl/pidq_integ.sv
module pidq_integ
    import pidq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  te_t                      te_i,
    input  logic signed [GAIN_W-1:0] kt,
    input  logic signed [SIG_W-1:0]  lo,
    input  logic signed [SIG_W-1:0]  hi,
    input  logic                     cond,
    output logic signed [SIG_W-1:0]  cmd,
    output logic                     cmd_sat,
    output logic signed [ACC_W-1:0]  integ,
    output logic                     pact
);
    typedef struct packed {
        logic signed [ACC_W-1:0] integ;
        logic                    pact;
        logic signed [SIG_W-1:0] cmd;
        logic                    sat;
    } st_t;

    st_t st_d, st_q;

    logic signed [WIDE_W-1:0] ipre_w;
    logic signed [WIDE_W-1:0] uraw_w;
    logic signed [WIDE_W-1:0] uclp_w;
    logic signed [WIDE_W-1:0] inext_w;
    logic                     clipped;

    always_comb begin
        st_d   = st_q;
        ipre_w = sat_w(WIDE_W'(st_q.integ) + WIDE_W'(te_i.kinc), ACC_W);
        if (te_i.act && st_q.pact) begin
            uraw_w = WIDE_W'(te_i.p) + ipre_w + WIDE_W'(te_i.d);
        end else begin
            uraw_w = WIDE_W'(te_i.trk);
        end
        uclp_w  = clamp_w(uraw_w, WIDE_W'(lo), WIDE_W'(hi));
        clipped = (uclp_w != uraw_w);

        if (te_i.act && !st_q.pact) begin
            inext_w = sat_w(WIDE_W'(te_i.trk) - WIDE_W'(te_i.p) - WIDE_W'(te_i.d), ACC_W);
        end else if (te_i.act) begin
            if (!clipped) begin
                inext_w = ipre_w;
            end else if (cond) begin
                inext_w = WIDE_W'(st_q.integ);
            end else begin
                inext_w = sat_w(ipre_w + rnd_sh(WIDE_W'(kt) * (uclp_w - uraw_w), GAIN_FRAC), ACC_W);
            end
        end else if (te_i.clr) begin
            inext_w = '0;
        end else begin
            inext_w = WIDE_W'(st_q.integ);
        end

        if (adv) begin
            st_d.integ = ACC_W'(inext_w);
            st_d.pact  = te_i.act;
            st_d.cmd   = SIG_W'(uclp_w);
            st_d.sat   = clipped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd     = st_q.cmd;
    assign cmd_sat = st_q.sat;
    assign integ   = st_q.integ;
    assign pact    = st_q.pact;
endmodule

// File: rtl/pid_fixq.sv
module pid_fixq
    import pidq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_stb,
    input  logic signed [SIG_W-1:0]  setpoint,
    input  logic signed [SIG_W-1:0]  meas,
    input  logic signed [GAIN_W-1:0] kp,
    input  logic signed [GAIN_W-1:0] ki,
    input  logic signed [GAIN_W-1:0] kd,
    input  logic signed [GAIN_W-1:0] kt,
    input  logic signed [SIG_W-1:0]  lpf_beta,
    input  logic signed [SIG_W-1:0]  cmd_lo,
    input  logic signed [SIG_W-1:0]  cmd_hi,
    input  logic                     run_en,
    input  logic                     auto_sel,
    input  logic                     fault,
    input  logic                     aw_cond,
    input  logic signed [SIG_W-1:0]  trk_val,
    output logic signed [SIG_W-1:0]  cmd,
    output logic                     cmd_sat,
    output logic                     cmd_vld
);
    localparam int PH_W = 2;
    localparam logic [PH_W-1:0] PH_IDLE = 2'd0;
    localparam logic [PH_W-1:0] PH_S1   = 2'd1;
    localparam logic [PH_W-1:0] PH_S2   = 2'd2;
    localparam logic [PH_W-1:0] PH_OUT  = 2'd3;

    logic [PH_W-1:0] phase_d, phase_q;
    logic            take;
    fe_t             fe_w;
    te_t             te_w;
    logic signed [ACC_W-1:0] integ_w;
    logic            pact_w;

    assign take = smp_stb && (phase_q == PH_IDLE || phase_q == PH_OUT);

    always_comb begin
        phase_d = phase_q;
        if (take) begin
            phase_d = PH_S1;
        end else begin
            case (phase_q)
                PH_S1:   phase_d = PH_S2;
                PH_S2:   phase_d = PH_OUT;
                PH_OUT:  phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    pidq_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (take),
        .sp       (setpoint),
        .y        (meas),
        .beta     (lpf_beta),
        .trk      (trk_val),
        .run_en   (run_en),
        .auto_sel (auto_sel),
        .fault    (fault),
        .fe       (fe_w)
    );

    pidq_terms u_terms (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (phase_q == PH_S1),
        .fe_i  (fe_w),
        .kp    (kp),
        .ki    (ki),
        .kd    (kd),
        .te    (te_w)
    );

    pidq_integ u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (phase_q == PH_S2),
        .te_i    (te_w),
        .kt      (kt),
        .lo      (cmd_lo),
        .hi      (cmd_hi),
        .cond    (aw_cond),
        .cmd     (cmd),
        .cmd_sat (cmd_sat),
        .integ   (integ_w),
        .pact    (pact_w)
    );

    assign cmd_vld = (phase_q == PH_OUT);
endmodule

module pid_fixq_chk
    import pidq_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_stb,
    input logic [1:0]              phase,
    input logic signed [SIG_W-1:0] cmd,
    input logic                    cmd_sat,
    input logic                    cmd_vld,
    input logic signed [SIG_W-1:0] cmd_lo,
    input logic signed [SIG_W-1:0] cmd_hi,
    input logic                    aw_cond,
    input te_t                     te,
    input logic signed [ACC_W-1:0] integ,
    input logic                    pact
);
    p_accept_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (phase == 2'd0 || phase == 2'd3)) |-> ##3 cmd_vld);

    p_vld_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> !cmd_vld);

    p_busy_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && phase == 2'd1) |-> ##3 !cmd_vld);

    p_cmd_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_lo <= cmd_hi) |-> (cmd >= cmd_lo && cmd <= cmd_hi));

    p_flag_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd > cmd_lo && cmd < cmd_hi) |-> !cmd_sat);

    p_cond_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && aw_cond && te.act && pact) |=> (!cmd_sat || $stable(integ)));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && !te.act && te.clr) |=> (integ == '0));
endmodule

bind pid_fixq pid_fixq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .phase   (phase_q),
    .cmd     (cmd),
    .cmd_sat (cmd_sat),
    .cmd_vld (cmd_vld),
    .cmd_lo  (cmd_lo),
    .cmd_hi  (cmd_hi),
    .aw_cond (aw_cond),
    .te      (te_w),
    .integ   (integ_w),
    .pact    (pact_w)
);

// File: tb/pid_fixq_test.sv
module pid_fixq_test;
    localparam int CLKP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic signed [15:0] setpoint = '0, meas = '0, kp = '0, ki = '0, kd = '0, kt = '0;
    logic signed [15:0] lpf_beta = 16'sd16384, cmd_lo = -16'sd16000, cmd_hi = 16'sd16000;
    logic signed [15:0] trk_val = '0;
    logic run_en = 1'b1, auto_sel = 1'b1, fault = 1'b0, aw_cond = 1'b0;
    logic signed [15:0] cmd;
    logic cmd_sat, cmd_vld;

    pid_fixq uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .setpoint(setpoint), .meas(meas),
        .kp(kp), .ki(ki), .kd(kd), .kt(kt), .lpf_beta(lpf_beta), .cmd_lo(cmd_lo),
        .cmd_hi(cmd_hi), .run_en(run_en), .auto_sel(auto_sel), .fault(fault),
        .aw_cond(aw_cond), .trk_val(trk_val), .cmd(cmd), .cmd_sat(cmd_sat), .cmd_vld(cmd_vld)
    );

    always #(CLKP/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R13";

    // reference model state
    longint m_integ = 0;
    longint m_yf = 0;
    bit     m_first = 1'b1;
    bit     m_pact = 1'b0;
    longint exp_cmd = 0;
    bit     exp_sat = 1'b0;
    longint cyc = 0;
    longint acc_cyc = -100;
    longint last_cmd = 0;
    bit     last_sat = 1'b0;
    int     vld_cnt = 0;

    function automatic longint bsat(longint v, int w);
        longint mx;
        mx = (longint'(1) <<< (w - 1)) - 1;
        if (v > mx) return mx;
        if (v < -mx - 1) return -mx - 1;
        return v;
    endfunction

    function automatic longint brnd(longint v, int s);
        return (v + (longint'(1) <<< (s - 1))) >>> s;
    endfunction

    function automatic longint bclamp(longint v, longint lo, longint hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    task automatic chk(string req, string what, longint got, longint want);
        n_chk++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, want);
        end
    endtask

    task automatic model_step();
        longint e, yfn, dy, p, d, kinc, u, uc, ipre;
        bit act;
        e = bsat(longint'(setpoint) - longint'(meas), 16);
        if (m_first) begin
            yfn = meas;
            dy  = 0;
        end else begin
            yfn = bsat(m_yf + brnd((longint'(meas) - m_yf) * longint'(lpf_beta), 14), 16);
            dy  = yfn - m_yf;
        end
        m_first = 1'b0;
        m_yf = yfn;
        p    = bsat(brnd(longint'(kp) * e, 11), 16);
        d    = bsat(-brnd(longint'(kd) * dy, 11), 16);
        kinc = bsat(brnd(longint'(ki) * e, 11), 32);
        act  = run_en && auto_sel && !fault;
        if (act && !m_pact) begin
            m_integ = bsat(longint'(trk_val) - p - d, 32);
            u = trk_val;
            uc = bclamp(u, cmd_lo, cmd_hi);
        end else if (act) begin
            ipre = bsat(m_integ + kinc, 32);
            u = p + ipre + d;
            uc = bclamp(u, cmd_lo, cmd_hi);
            if (uc == u) m_integ = ipre;
            else if (!aw_cond) m_integ = bsat(ipre + brnd(longint'(kt) * (uc - u), 11), 32);
        end else begin
            u = trk_val;
            uc = bclamp(u, cmd_lo, cmd_hi);
            if (!run_en || fault) m_integ = 0;
        end
        m_pact  = act;
        exp_cmd = uc;
        exp_sat = (uc != u);
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit expv;
            cyc++;
            expv = (cyc == acc_cyc + 3);
            if (cmd_vld) begin
                vld_cnt++;
                last_cmd = cmd;
                last_sat = cmd_sat;
            end
            if (expv || cmd_vld) begin
                chk("R1", "cmd_vld", longint'(cmd_vld), longint'(expv));
                if (expv && cmd_vld) begin
                    chk(cur_req, "cmd", longint'(cmd), exp_cmd);
                    chk(cur_req, "cmd_sat", longint'(cmd_sat), longint'(exp_sat));
                end
            end
            if (smp_stb && (cyc - acc_cyc >= 3)) begin
                model_step();
                acc_cyc = cyc;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLKP/4);
    endtask

    task automatic sample();
        smp_stb = 1'b1;
        tick();
        smp_stb = 1'b0;
        tick();
        tick();
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint hold_a;
        int v0;
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // R13: reset values
        chk("R13", "cmd", longint'(cmd), 0);
        chk("R13", "cmd_sat", longint'(cmd_sat), 0);
        chk("R13", "cmd_vld", longint'(cmd_vld), 0);

        // R10: first automatic sample preloads to the tracked value
        cur_req = "R10";
        kp = 16'sd2048; ki = 16'sd100; trk_val = 16'sd1234;
        setpoint = 16'sd3000; meas = 16'sd1000;
        sample();
        chk("R10", "first auto cmd", last_cmd, 1234);

        // R3 and R6: proportional and integral under varied errors
        cur_req = "R6";
        kp = 16'sd3000; ki = 16'sd200;
        for (int i = 0; i < 20; i++) begin
            setpoint = 16'((i * 3713) % 20000 - 10000);
            meas     = 16'((i * 1291) % 12000 - 6000);
            sample();
        end
        cur_req = "R3";
        ki = 16'sd0; kp = -16'sd5000;
        for (int i = 0; i < 8; i++) begin
            setpoint = 16'(i * 2001 - 7000);
            meas     = 16'(3000 - i * 900);
            sample();
        end

        // R4 and R5: filtered derivative
        cur_req = "R4";
        kp = 16'sd1000; kd = 16'sd20000; lpf_beta = 16'sd4096;
        for (int i = 0; i < 20; i++) begin
            meas = 16'(((i * i * 577) % 16000) - 8000);
            sample();
        end
        // R5: setpoint step with constant measurement gives no derivative change
        cur_req = "R5";
        kp = 16'sd0; ki = 16'sd0; kd = 16'sd30000; lpf_beta = 16'sd16384;
        meas = 16'sd2000; setpoint = 16'sd0;
        sample();
        sample();
        hold_a = last_cmd;
        setpoint = 16'sd8000;
        sample();
        chk("R5", "cmd after setpoint step", last_cmd, hold_a);

        // R7 and R8: clipping with back-calculation
        cur_req = "R8";
        kd = 16'sd0; kp = 16'sd4096; ki = 16'sd1000; kt = 16'sd2048;
        cmd_lo = -16'sd4000; cmd_hi = 16'sd4000; aw_cond = 1'b0;
        setpoint = 16'sd6000; meas = 16'sd0;
        for (int i = 0; i < 8; i++) sample();
        chk("R7", "clipped cmd", last_cmd, 4000);
        chk("R7", "clip flag", longint'(last_sat), 1);
        setpoint = -16'sd1500;
        for (int i = 0; i < 6; i++) sample();

        // R9: conditional integration
        cur_req = "R9";
        aw_cond = 1'b1;
        setpoint = 16'sd7000;
        for (int i = 0; i < 6; i++) sample();
        setpoint = 16'sd0;
        for (int i = 0; i < 6; i++) sample();
        aw_cond = 1'b0;

        // R2: strobe held high across busy cycles
        cur_req = "R2";
        v0 = vld_cnt;
        smp_stb = 1'b1;
        for (int i = 0; i < 9; i++) begin
            setpoint = 16'(i * 500);
            tick();
        end
        smp_stb = 1'b0;
        tick(); tick(); tick();
        chk("R2", "results from 9 strobe cycles", longint'(vld_cnt - v0), 3);

        // R11: tracking in manual, fault and disable
        cur_req = "R11";
        auto_sel = 1'b0; trk_val = 16'sd5000;
        sample();
        chk("R11", "manual clipped cmd", last_cmd, 4000);
        chk("R11", "manual clip flag", longint'(last_sat), 1);
        trk_val = 16'sd100;
        sample();
        chk("R11", "manual cmd", last_cmd, 100);
        auto_sel = 1'b1; fault = 1'b1; trk_val = -16'sd250;
        sample();
        chk("R11", "fault cmd", last_cmd, -250);
        fault = 1'b0; run_en = 1'b0; trk_val = 16'sd321;
        sample();
        chk("R11", "disabled cmd", last_cmd, 321);
        cur_req = "R10";
        run_en = 1'b1; trk_val = 16'sd777;
        setpoint = 16'sd2500; meas = 16'sd100;
        sample();
        chk("R10", "preload after enable", last_cmd, 777);
        sample();

        // R12: integrator saturates instead of wrapping
        cur_req = "R12";
        cmd_lo = -16'sd16000; cmd_hi = 16'sd16000;
        kp = 16'sd0; kd = 16'sd0; kt = 16'sd0; ki = 16'sd32767;
        setpoint = 16'sd16383; meas = -16'sd16384;
        for (int i = 0; i < 4200; i++) sample();
        chk("R12", "cmd at long clip", last_cmd, 16000);
        chk("R12", "flag at long clip", longint'(last_sat), 1);
        setpoint = -16'sd16384; meas = 16'sd16383;
        for (int i = 0; i < 4; i++) sample();
        chk("R12", "cmd after reversal", last_cmd, 16000);

        tick();
        finish_run();
    end
endmodule